// File: doc/BRIEF.md
# Reset and Output Enable Controller

This block conditions the two board-level pins that decide when a serial-stream switching device may drive its outputs: an active-low reset and an output-drive-enable. A low reset clears the internal logic at once, with no clock needed. The release of reset is brought onto the internal clock through a two-flop synchroniser. The internal reset is then held for a further fixed settling time, nominally 50 µs, so that a clock multiplier can lock. A status output marks the end of that stretch so that other blocks can begin their initialisation.

The stream outputs fall into two groups: local lanes and backplane lanes. Each group has its own mode pin. While the block is idle, that pin chooses whether the group's lanes are driven high or released to high-impedance. The block is idle while the internal reset is active or while the synchronised drive-enable is low. For each lane the block provides a data value and an active-high drive enable, which feed the pad tri-state buffers. While idle, the buffer-control outputs for optional external drivers are held low. Normal data flows only once the settling stretch is over and the drive-enable pin has been seen high through its synchroniser.

Top module: `rstoe_top`

## Requirements
- R1: A low level on `rstExtN` takes `initDone` low, every buffer-control output low, and every lane to its idle level at once, without waiting for a clock edge.
- R2: With `rstExtN` released between clock edges, `initDone` is low after the (STRETCH_CYCLES+1)th following rising edge and high after the (STRETCH_CYCLES+2)th, where STRETCH_CYCLES = CLK_KHZ*STRETCH_US/1000 (819 with the defaults). Once high, it stays high until `rstExtN` goes low again.
- R3: While idle with `localFloatSel` = 1, every `localOutEn` bit is 0 (high-impedance). With `localFloatSel` = 0, every `localOut` and `localOutEn` bit is 1 (driven high).
- R4: The backplane lanes follow `bpFloatSel` under the same encoding as R3, independently of `localFloatSel`.
- R5: While the synchronised drive-enable is low, `localBufCtl` and `bpBufCtl` are all zeros and both lane groups sit at their idle levels from R3 and R4.
- R6: When `initDone` is high and drive is enabled, `localOut` equals `localData`, `bpOut` equals `bpData`, every drive-enable bit is 1, and every buffer-control bit is 1. With the pin already high, drive starts on the second rising edge after `initDone` rises.
- R7: A change on `driveEnPin`, applied between edges, reaches the outputs on the second following rising edge and not the first.
- R8: A reset pulse of at least two clock cycles that arrives during the settling stretch restarts it, so `initDone` rises exactly as in R2, counted from the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstExtN | input | 1 | External reset, active low, asynchronous assert |
| driveEnPin | input | 1 | Output-drive-enable pin, asynchronous |
| localFloatSel | input | 1 | Local idle mode: 1 float, 0 drive high |
| bpFloatSel | input | 1 | Backplane idle mode: 1 float, 0 drive high |
| localData | input | LOCAL_LANES | Stream data for local lanes |
| bpData | input | BP_LANES | Stream data for backplane lanes |
| localOut | output | LOCAL_LANES | Local lane pad values |
| localOutEn | output | LOCAL_LANES | Local lane pad drive enables |
| bpOut | output | BP_LANES | Backplane lane pad values |
| bpOutEn | output | BP_LANES | Backplane lane pad drive enables |
| localBufCtl | output | BUF_GROUPS | Local external buffer controls |
| bpBufCtl | output | BUF_GROUPS | Backplane external buffer controls |
| initDone | output | 1 | High once the reset stretch has finished |

## Verification
The hardest case to reach from the ports is a reset that arrives partway through the settling stretch. The counter is then neither at zero nor at terminal count, and it must be shown to start again from zero rather than carry on. The bench releases reset, lets roughly a hundred cycles pass, and pulses reset low for three cycles. It then counts rising edges from the new release and checks that `initDone` is still low one edge before the terminal cycle and high on it. A second hard case is the asynchronous assertion. The bench drops reset one time step after a falling edge and samples the outputs before any rising edge can occur.

// File: rtl/rstoe_pkg.sv
package rstoe_pkg;

  // Strobes passed from the control section to the lane datapath
  typedef struct packed {
    logic coreRst;   // internal reset (including stretch) active
    logic driveOk;   // lanes may carry normal data
  } laneCtl_t;

endpackage

// File: rtl/rstoe_ctrl.sv
module rstoe_ctrl
  import rstoe_pkg::*;
#(
  parameter int CLK_KHZ    = 16384,
  parameter int STRETCH_US = 50
) (
  input  logic     clk,
  input  logic     rstExtN,
  input  logic     driveEnPin,
  output laneCtl_t strobes,
  output logic     initDone
);

  localparam int STRETCH_CYCLES = (CLK_KHZ * STRETCH_US) / 1000;
  localparam int CW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CW-1:0] TERMINAL = CW'(STRETCH_CYCLES);

  logic [1:0]    rstSync;
  logic          syncRstN;
  logic [CW-1:0] stretchCnt;
  logic          stretchDone;
  logic [1:0]    enSync;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rstExtN) begin
    if (!rstExtN) rstSync <= 2'b00;
    else          rstSync <= {rstSync[0], 1'b1};
  end

  assign syncRstN = rstSync[1];

  // Settling stretch counter, saturates at its terminal value
  always_ff @(posedge clk or negedge rstExtN) begin
    if (!rstExtN)          stretchCnt <= '0;
    else if (!syncRstN)    stretchCnt <= '0;
    else if (!stretchDone) stretchCnt <= stretchCnt + CW'(1);
  end

  assign stretchDone = (stretchCnt == TERMINAL);

  // Drive-enable synchroniser, held at default during internal reset
  always_ff @(posedge clk or negedge rstExtN) begin
    if (!rstExtN)          enSync <= 2'b00;
    else if (!stretchDone) enSync <= 2'b00;
    else                   enSync <= {enSync[0], driveEnPin};
  end

  assign strobes.coreRst = !stretchDone;
  assign strobes.driveOk = enSync[1] & stretchDone;
  assign initDone        = stretchDone;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstExtN)
    stretchCnt <= TERMINAL);  // R2

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstExtN)
    initDone |=> initDone);  // R2

  AST_NO_DRIVE_IN_RESET: assert property (@(posedge clk) disable iff (!rstExtN)
    !syncRstN |=> !strobes.driveOk);  // R5

endmodule

// File: rtl/rstoe_group.sv
module rstoe_group
  import rstoe_pkg::*;
#(
  parameter int LANES = 32,
  parameter int BUFS  = 4
) (
  input  laneCtl_t         strobes,
  input  logic             floatSel,
  input  logic [LANES-1:0] laneData,
  output logic [LANES-1:0] laneOut,
  output logic [LANES-1:0] laneOutEn,
  output logic [BUFS-1:0]  bufCtl
);

  logic idleDriveEn;
  assign idleDriveEn = ~floatSel;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneOut[i]   = strobes.driveOk ? laneData[i] : 1'b1;
    assign laneOutEn[i] = strobes.driveOk | idleDriveEn;
  end

  for (genvar b = 0; b < BUFS; b++) begin : g_buf
    assign bufCtl[b] = strobes.driveOk & ~strobes.coreRst;
  end

endmodule

// File: rtl/rstoe_lanes.sv
module rstoe_lanes
  import rstoe_pkg::*;
#(
  parameter int LOCAL_LANES = 32,
  parameter int BP_LANES    = 32,
  parameter int BUF_GROUPS  = 4
) (
  input  laneCtl_t               strobes,
  input  logic                   localFloatSel,
  input  logic                   bpFloatSel,
  input  logic [LOCAL_LANES-1:0] localData,
  input  logic [BP_LANES-1:0]    bpData,
  output logic [LOCAL_LANES-1:0] localOut,
  output logic [LOCAL_LANES-1:0] localOutEn,
  output logic [BP_LANES-1:0]    bpOut,
  output logic [BP_LANES-1:0]    bpOutEn,
  output logic [BUF_GROUPS-1:0]  localBufCtl,
  output logic [BUF_GROUPS-1:0]  bpBufCtl
);

  rstoe_group #(.LANES(LOCAL_LANES), .BUFS(BUF_GROUPS)) u_local (
    .strobes  (strobes),
    .floatSel (localFloatSel),
    .laneData (localData),
    .laneOut  (localOut),
    .laneOutEn(localOutEn),
    .bufCtl   (localBufCtl)
  );

  rstoe_group #(.LANES(BP_LANES), .BUFS(BUF_GROUPS)) u_bp (
    .strobes  (strobes),
    .floatSel (bpFloatSel),
    .laneData (bpData),
    .laneOut  (bpOut),
    .laneOutEn(bpOutEn),
    .bufCtl   (bpBufCtl)
  );

endmodule

// File: rtl/rstoe_top.sv
module rstoe_top
  import rstoe_pkg::*;
#(
  parameter int CLK_KHZ     = 16384,
  parameter int STRETCH_US  = 50,
  parameter int LOCAL_LANES = 32,
  parameter int BP_LANES    = 32,
  parameter int BUF_GROUPS  = 4
) (
  input  logic                   clk,
  input  logic                   rstExtN,
  input  logic                   driveEnPin,
  input  logic                   localFloatSel,
  input  logic                   bpFloatSel,
  input  logic [LOCAL_LANES-1:0] localData,
  input  logic [BP_LANES-1:0]    bpData,
  output logic [LOCAL_LANES-1:0] localOut,
  output logic [LOCAL_LANES-1:0] localOutEn,
  output logic [BP_LANES-1:0]    bpOut,
  output logic [BP_LANES-1:0]    bpOutEn,
  output logic [BUF_GROUPS-1:0]  localBufCtl,
  output logic [BUF_GROUPS-1:0]  bpBufCtl,
  output logic                   initDone
);

  laneCtl_t strobes;

  rstoe_ctrl #(.CLK_KHZ(CLK_KHZ), .STRETCH_US(STRETCH_US)) u_ctrl (
    .clk       (clk),
    .rstExtN   (rstExtN),
    .driveEnPin(driveEnPin),
    .strobes   (strobes),
    .initDone  (initDone)
  );

  rstoe_lanes #(
    .LOCAL_LANES(LOCAL_LANES),
    .BP_LANES   (BP_LANES),
    .BUF_GROUPS (BUF_GROUPS)
  ) u_lanes (
    .strobes      (strobes),
    .localFloatSel(localFloatSel),
    .bpFloatSel   (bpFloatSel),
    .localData    (localData),
    .bpData       (bpData),
    .localOut     (localOut),
    .localOutEn   (localOutEn),
    .bpOut        (bpOut),
    .bpOutEn      (bpOutEn),
    .localBufCtl  (localBufCtl),
    .bpBufCtl     (bpBufCtl)
  );

  AST_BUF_LOW_IN_RESET: assert property (@(posedge clk) disable iff (!rstExtN)
    !initDone |-> (localBufCtl == '0) && (bpBufCtl == '0));  // R5

  AST_LOCAL_FLOAT: assert property (@(posedge clk) disable iff (!rstExtN)
    (!initDone && localFloatSel) |-> (localOutEn == '0));  // R3

  AST_BP_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rstExtN)
    (!initDone && !bpFloatSel) |-> ((&bpOut) && (&bpOutEn)));  // R4

endmodule

// File: tb/rstoe_top_tb.sv
module rstoe_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int KHZ = 16384;
  localparam int US  = 50;
  localparam int STRETCH = (KHZ * US) / 1000;
  localparam int LW = 32;
  localparam int BW = 32;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rstExtN = 1'b0;
  logic          driveEnPin = 1'b0;
  logic          localFloatSel = 1'b0;
  logic          bpFloatSel = 1'b0;
  logic [LW-1:0] localData = '0;
  logic [BW-1:0] bpData = '0;
  logic [LW-1:0] localOut, localOutEn;
  logic [BW-1:0] bpOut, bpOutEn;
  logic [NB-1:0] localBufCtl, bpBufCtl;
  logic          initDone;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstoe_top #(.CLK_KHZ(KHZ), .STRETCH_US(US), .LOCAL_LANES(LW),
              .BP_LANES(BW), .BUF_GROUPS(NB)) u_dut (
    .clk(clk), .rstExtN(rstExtN), .driveEnPin(driveEnPin),
    .localFloatSel(localFloatSel), .bpFloatSel(bpFloatSel),
    .localData(localData), .bpData(bpData),
    .localOut(localOut), .localOutEn(localOutEn),
    .bpOut(bpOut), .bpOutEn(bpOutEn),
    .localBufCtl(localBufCtl), .bpBufCtl(bpBufCtl),
    .initDone(initDone)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edgesThenSample(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Idle-level check for both groups (R3, R4, R5)
  task automatic chkIdle(input string tag);
    logic [LW-1:0] expLEn;
    logic [BW-1:0] expBEn;
    expLEn = localFloatSel ? '0 : '1;
    expBEn = bpFloatSel ? '0 : '1;
    chk(localOutEn == expLEn, {tag, " R3 localOutEn"}, 64'(localOutEn), 64'(expLEn));
    if (!localFloatSel)
      chk(localOut == '1, {tag, " R3 localOut"}, 64'(localOut), 64'hFFFFFFFF);
    chk(bpOutEn == expBEn, {tag, " R4 bpOutEn"}, 64'(bpOutEn), 64'(expBEn));
    if (!bpFloatSel)
      chk(bpOut == '1, {tag, " R4 bpOut"}, 64'(bpOut), 64'hFFFFFFFF);
    chk({localBufCtl, bpBufCtl} == '0, {tag, " R5 bufCtl"},
        64'({localBufCtl, bpBufCtl}), 64'h0);
  endtask

  task automatic chkActive(input string tag);
    chk(localOut == localData, {tag, " R6 localOut"}, 64'(localOut), 64'(localData));
    chk(bpOut == bpData, {tag, " R6 bpOut"}, 64'(bpOut), 64'(bpData));
    chk((&localOutEn) && (&bpOutEn), {tag, " R6 outEn"},
        64'({localOutEn, bpOutEn}), 64'hFFFFFFFFFFFFFFFF);
    chk((&localBufCtl) && (&bpBufCtl), {tag, " R6 bufCtl"},
        64'({localBufCtl, bpBufCtl}), 64'hFF);
  endtask

  // Reset-time idle levels in all four mode combinations
  task automatic tResetModes();
    @(negedge clk);
    chk(initDone == 1'b0, "R1 initDone in reset", 64'(initDone), 64'h0);
    for (int m = 0; m < 4; m++) begin
      localFloatSel = m[0];
      bpFloatSel    = m[1];
      localData = 32'hA5A5_0F0F;
      bpData    = 32'h1234_5678;
      #1;
      chkIdle("reset");
    end
    localFloatSel = 1'b0;
    bpFloatSel    = 1'b1;
  endtask

  // Release and count the stretch; pin already high
  task automatic tStretch();
    driveEnPin = 1'b1;
    @(negedge clk);
    rstExtN = 1'b1;
    edgesThenSample(STRETCH + 1);
    chk(initDone == 1'b0, "R2 initDone one edge early", 64'(initDone), 64'h0);
    chkIdle("stretch");
    edgesThenSample(1);
    chk(initDone == 1'b1, "R2 initDone at terminal", 64'(initDone), 64'h1);
    edgesThenSample(1);
    chk({localBufCtl, bpBufCtl} == '0, "R6 drive not yet on",
        64'({localBufCtl, bpBufCtl}), 64'h0);
    edgesThenSample(1);
    chkActive("stretch end");
  endtask

  task automatic tNormalData();
    logic [31:0] pat [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h8000_0001};
    for (int i = 0; i < 4; i++) begin
      localData = pat[i];
      bpData    = ~pat[i];
      #1;
      chkActive("data");
    end
    edgesThenSample(20);
    chk(initDone == 1'b1, "R2 initDone sticky", 64'(initDone), 64'h1);
  endtask

  task automatic tEnable();
    driveEnPin = 1'b0;
    edgesThenSample(1);
    chkActive("R7 still on after one edge");
    edgesThenSample(1);
    chkIdle("R7 disabled");
    localFloatSel = 1'b1;
    bpFloatSel    = 1'b0;
    #1;
    chkIdle("R5 disabled modes");
    driveEnPin = 1'b1;
    edgesThenSample(1);
    chkIdle("R7 still off after one edge");
    edgesThenSample(1);
    chkActive("R7 re-enabled");
  endtask

  task automatic tAsyncReset();
    @(negedge clk);
    #1;
    rstExtN = 1'b0;
    #1;
    chk(initDone == 1'b0, "R1 async initDone", 64'(initDone), 64'h0);
    chkIdle("R1 async");
    edgesThenSample(3);
    rstExtN = 1'b1;
  endtask

  // Release, interrupt mid-stretch, then count from the new release
  task automatic tRestart();
    edgesThenSample(100);
    chk(initDone == 1'b0, "R8 mid-stretch", 64'(initDone), 64'h0);
    rstExtN = 1'b0;
    edgesThenSample(3);
    rstExtN = 1'b1;
    edgesThenSample(STRETCH + 1);
    chk(initDone == 1'b0, "R8 restarted stretch early", 64'(initDone), 64'h0);
    edgesThenSample(1);
    chk(initDone == 1'b1, "R8 restarted stretch terminal", 64'(initDone), 64'h1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog actual=%h expected=%h", 64'h1, 64'h0);
    finish();
  end

  initial begin
    edgesThenSample(3);
    tResetModes();
    tStretch();
    tNormalData();
    tEnable();
    tAsyncReset();
    tRestart();
    finish();
  end

endmodule